// File: doc/BRIEF.md
# Disk Task-File Register Unit

This block is the set of registers a host sees when it talks to a disk drive over a 16-bit asynchronous I/O bus. The host selects a register with two active-low chip selects, one for the command group and one for the control group, together with a 3-bit address. It then pulses a read or a write strobe. The strobes arrive already synchronised to the drive clock as one-cycle pulses. The unit stores the sector, cylinder and head parameters and passes each command code to the drive's sequencer. It also keeps the interrupt request, the interrupt mask and the software reset bit. While the drive owns the registers, a busy flag locks the host out of them.

The sequencer sees the stored parameters, a one-cycle command strobe and the data-port strobes. It reports back through several inputs:
- a completion pulse that carries an error code;
- a pulse that updates the stored parameters;
- a pulse that sets busy;
- an initialisation-done pulse that ends a reset.

Two drives can share the bus. Each drive compares the drive-select bit in its drive/head register with its own master/slave strap. Only the selected drive answers reads or raises an interrupt. Both drives accept every write.

Top module: `taskfile_regs`

## Requirements
- R1: With the command select low and the control select high, a read at address 1 returns the error register, 2 the sector count, 3 the sector number, 4 cylinder bits 7:0, 5 cylinder bits 15:8 and 7 the status byte {busy, drv_status[6:0]}. These reads drive bus bits 7:0 (dd_oe = 3'b011). A read at address 0 returns the 16-bit sequencer data word on all bits (dd_oe = 3'b111).
- R2: A write at command address 1 loads the write-precompensation value (tf_precomp) and leaves the error register unchanged. Writes at addresses 2 to 6 load the matching parameter registers.
- R3: With the control select low, address 6 reads the status byte and a write there loads the control register. In the control register, bit 2 is software reset and bit 1 is the interrupt mask. When both selects are equal, or the control group is addressed at 0 to 5, the bus is not driven (dd_oe = 0) and writes have no effect.
- R4: A status read at command address 7 clears a pending interrupt. A read of the same byte at control address 6 leaves the interrupt pending.
- R5: intrq_oe is high only when three conditions hold: an interrupt is pending, the drive is selected and mask bit 1 is 0.
- R6: A hardware reset, or setting the software reset bit, drives drive_rst high and sets busy at once. Busy then stays set until init_done arrives with the reset released. It clears without raising an interrupt.
- R7: After a reset and init_done, the registers read: error 01h, sector count 01h, sector number 01h, both cylinder bytes 00h, drive/head A0h.
- R8: While busy is set, every command-group read returns the status byte, and host writes to the command group have no effect.
- R9: Drive/head reads as {3'b101, DRV, head[3:0]}. DRV = 0 selects the master and DRV = 1 selects the slave.
- R10: A read at control address 7 drives bits 6:0 only (dd_oe = 3'b001) as follows:
  - bit 6 is wr_gate_n;
  - bits 5:2 are the inverted head number;
  - bits 1:0 are active-low drive selects: 2'b10 for the master, 2'b01 for the slave.
- R11: A write at command address 7 gives cmd_strobe for one cycle with cmd_code equal to the written byte. Busy is set unless the code is a data-out command: 30h to 33h, 50h, C5h or E8h.
- R12: A drive whose DRV bit differs from strap_slave drives nothing on reads but still accepts writes.
- R13: seq_done clears busy, loads seq_err into the error register and sets the interrupt pending. seq_upd loads the sector count, sector number, cylinder and head from the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Drive clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| strap_slave | input | 1 | Strap: 1 makes this drive the slave |
| cs_cmd_n | input | 1 | Command-group select, active low |
| cs_ctl_n | input | 1 | Control-group select, active low |
| addr | input | 3 | Register address |
| rd_stb | input | 1 | Host read pulse |
| wr_stb | input | 1 | Host write pulse |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data |
| dd_oe | output | 3 | Bus drive enables: bit0 = bits 6:0, bit1 = bit 7, bit2 = bits 15:8 |
| iocs16_n | output | 1 | Low when the 16-bit data port is addressed and open |
| intrq | output | 1 | Interrupt level, valid while intrq_oe is high |
| intrq_oe | output | 1 | Interrupt line drive enable |
| drive_rst | output | 1 | Holds the drive in reset |
| cmd_strobe | output | 1 | One-cycle command start |
| cmd_code | output | 8 | Last command code written |
| dport_rd | output | 1 | Host is reading the data port |
| dport_wr | output | 1 | Host is writing the data port |
| dport_wdata | output | 16 | Data-port write word |
| dport_rdata | input | 16 | Data-port read word from the buffer |
| tf_precomp | output | 8 | Precompensation value |
| tf_sc | output | 8 | Sector count |
| tf_sn | output | 8 | Sector number |
| tf_cyl | output | 16 | Cylinder |
| tf_head | output | 4 | Head number |
| tf_drv | output | 1 | Drive-select bit |
| drv_status | input | 7 | Status bits 6:0 from the sequencer |
| wr_gate_n | input | 1 | Write gate, active low, shown in the drive address byte |
| init_done | input | 1 | Initialisation after reset is complete |
| seq_done | input | 1 | Command complete |
| seq_err | input | 8 | Error code given with seq_done |
| seq_busy_set | input | 1 | Sequencer takes the registers |
| seq_upd | input | 1 | Load parameters from the sequencer |
| seq_sc | input | 8 | New sector count |
| seq_sn | input | 8 | New sector number |
| seq_cyl | input | 16 | New cylinder |
| seq_head | input | 4 | New head |

## Verification
The assertions hold on every cycle. They check:
- the interrupt line is enabled only with a pending, selected, unmasked interrupt;
- status reads acknowledge the interrupt and alternate-status reads do not;
- invalid select pairs leave the bus undriven;
- software reset always implies busy, and no interrupt is pending during initialisation;
- the parameter registers hold still under a locked-out write;
- every command strobe follows a command-register write.

Only the bench scenarios can show the rest:
- the actual register contents through the read decode;
- the defaults after both kinds of reset;
- which command codes leave busy clear;
- the master/slave hand-off, where an unselected drive keeps accepting writes.

// File: rtl/taskfile_regs.sv
module taskfile_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_slave,
  input  logic        cs_cmd_n,
  input  logic        cs_ctl_n,
  input  logic [2:0]  addr,
  input  logic        rd_stb,
  input  logic        wr_stb,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic [2:0]  dd_oe,
  output logic        iocs16_n,
  output logic        intrq,
  output logic        intrq_oe,
  output logic        drive_rst,
  output logic        cmd_strobe,
  output logic [7:0]  cmd_code,
  output logic        dport_rd,
  output logic        dport_wr,
  output logic [15:0] dport_wdata,
  input  logic [15:0] dport_rdata,
  output logic [7:0]  tf_precomp,
  output logic [7:0]  tf_sc,
  output logic [7:0]  tf_sn,
  output logic [15:0] tf_cyl,
  output logic [3:0]  tf_head,
  output logic        tf_drv,
  input  logic [6:0]  drv_status,
  input  logic        wr_gate_n,
  input  logic        init_done,
  input  logic        seq_done,
  input  logic [7:0]  seq_err,
  input  logic        seq_busy_set,
  input  logic        seq_upd,
  input  logic [7:0]  seq_sc,
  input  logic [7:0]  seq_sn,
  input  logic [15:0] seq_cyl,
  input  logic [3:0]  seq_head
);

  localparam logic [7:0] ERR_DEF = 8'h01;
  localparam logic [7:0] SC_DEF  = 8'h01;
  localparam logic [7:0] SN_DEF  = 8'h01;
  localparam logic [2:0] A_DATA  = 3'd0;
  localparam logic [2:0] A_ALT   = 3'd6;
  localparam logic [2:0] A_STAT  = 3'd7;

  logic       busy, init_wait, irq_pend;
  logic       dor_srst, dor_nien;
  logic       cmd_q;
  logic [7:0] code_q, err_q, pc_q, sc_q, sn_q, cl_q, ch_q;
  logic       dh_drv;
  logic [3:0] dh_head;

  logic       cmd_sel, ctl_sel, selected, dor_wr, srst_next, tf_wr, stat_ack;
  logic [7:0] status;

  function automatic logic data_out_cmd(input logic [7:0] c);
    return (c[7:2] == 6'b001100) || (c == 8'h50) || (c == 8'hC5) || (c == 8'hE8);
  endfunction

  assign cmd_sel   = !cs_cmd_n && cs_ctl_n;
  assign ctl_sel   = cs_cmd_n && !cs_ctl_n;
  assign selected  = (dh_drv == strap_slave);
  assign status    = {busy, drv_status};
  assign dor_wr    = wr_stb && ctl_sel && (addr == A_ALT);
  assign srst_next = dor_wr ? wdata[2] : dor_srst;
  assign tf_wr     = wr_stb && cmd_sel && !busy;
  assign stat_ack  = rd_stb && cmd_sel && (addr == A_STAT) && selected;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b1;
      init_wait <= 1'b1;
      irq_pend  <= 1'b0;
      dor_srst  <= 1'b0;
      dor_nien  <= 1'b0;
      cmd_q     <= 1'b0;
      code_q    <= 8'h00;
      pc_q      <= 8'h00;
      err_q     <= ERR_DEF;
      sc_q      <= SC_DEF;
      sn_q      <= SN_DEF;
      cl_q      <= 8'h00;
      ch_q      <= 8'h00;
      dh_drv    <= 1'b0;
      dh_head   <= 4'h0;
    end else begin
      cmd_q <= 1'b0;
      if (dor_wr) begin
        dor_srst <= wdata[2];
        dor_nien <= wdata[1];
      end
      if (srst_next) begin
        busy      <= 1'b1;
        init_wait <= 1'b1;
        irq_pend  <= 1'b0;
        err_q     <= ERR_DEF;
        sc_q      <= SC_DEF;
        sn_q      <= SN_DEF;
        cl_q      <= 8'h00;
        ch_q      <= 8'h00;
        dh_drv    <= 1'b0;
        dh_head   <= 4'h0;
      end else if (init_wait) begin
        if (init_done) begin
          busy      <= 1'b0;
          init_wait <= 1'b0;
        end
      end else begin
        if (stat_ack) irq_pend <= 1'b0;
        if (tf_wr) begin
          case (addr)
            3'd1: pc_q <= wdata[7:0];
            3'd2: sc_q <= wdata[7:0];
            3'd3: sn_q <= wdata[7:0];
            3'd4: cl_q <= wdata[7:0];
            3'd5: ch_q <= wdata[7:0];
            3'd6: begin
              dh_drv  <= wdata[4];
              dh_head <= wdata[3:0];
            end
            3'd7: begin
              cmd_q  <= 1'b1;
              code_q <= wdata[7:0];
              busy   <= !data_out_cmd(wdata[7:0]);
            end
            default: ;
          endcase
        end
        if (seq_busy_set) busy <= 1'b1;
        if (seq_done) begin
          busy     <= 1'b0;
          err_q    <= seq_err;
          irq_pend <= 1'b1;
        end
        if (seq_upd) begin
          sc_q    <= seq_sc;
          sn_q    <= seq_sn;
          cl_q    <= seq_cyl[7:0];
          ch_q    <= seq_cyl[15:8];
          dh_head <= seq_head;
        end
      end
    end
  end

  always_comb begin
    rdata    = 16'h0000;
    dd_oe    = 3'b000;
    dport_rd = 1'b0;
    if (rd_stb && selected) begin
      if (cmd_sel) begin
        dd_oe = 3'b011;
        if (busy) begin
          rdata = {8'h00, status};
        end else begin
          case (addr)
            3'd0: begin
              rdata    = dport_rdata;
              dd_oe    = 3'b111;
              dport_rd = 1'b1;
            end
            3'd1: rdata = {8'h00, err_q};
            3'd2: rdata = {8'h00, sc_q};
            3'd3: rdata = {8'h00, sn_q};
            3'd4: rdata = {8'h00, cl_q};
            3'd5: rdata = {8'h00, ch_q};
            3'd6: rdata = {8'h00, 3'b101, dh_drv, dh_head};
            default: rdata = {8'h00, status};
          endcase
        end
      end else if (ctl_sel) begin
        if (addr == A_ALT) begin
          dd_oe = 3'b011;
          rdata = {8'h00, status};
        end else if (addr == A_STAT) begin
          dd_oe = 3'b001;
          rdata = {9'h000, wr_gate_n, ~dh_head, dh_drv ? 2'b01 : 2'b10};
        end
      end
    end
  end

  assign iocs16_n    = !(cmd_sel && (addr == A_DATA) && selected && !busy);
  assign dport_wr    = wr_stb && cmd_sel && (addr == A_DATA) && !busy;
  assign dport_wdata = wdata;
  assign intrq_oe    = irq_pend && selected && !dor_nien;
  assign intrq       = intrq_oe;
  assign drive_rst   = dor_srst || !rst_n;
  assign cmd_strobe  = cmd_q;
  assign cmd_code    = code_q;
  assign tf_precomp  = pc_q;
  assign tf_sc       = sc_q;
  assign tf_sn       = sn_q;
  assign tf_cyl      = {ch_q, cl_q};
  assign tf_head     = dh_head;
  assign tf_drv      = dh_drv;

endmodule

// File: rtl/taskfile_regs_chk.sv
module taskfile_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       strap_slave,
  input logic       cs_cmd_n,
  input logic       cs_ctl_n,
  input logic [2:0] addr,
  input logic       rd_stb,
  input logic       wr_stb,
  input logic [2:0] dd_oe,
  input logic       intrq_oe,
  input logic       cmd_strobe,
  input logic       seq_done,
  input logic       seq_upd,
  input logic       busy,
  input logic       init_wait,
  input logic       irq_pend,
  input logic       dor_srst,
  input logic       dor_nien,
  input logic       dh_drv,
  input logic [7:0] sc_q,
  input logic [7:0] sn_q,
  input logic [7:0] cl_q,
  input logic [7:0] ch_q
);

  a_r3_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_cmd_n == cs_ctl_n) |-> (dd_oe == 3'b000));

  a_r5_intrq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    intrq_oe |-> (irq_pend && (dh_drv == strap_slave) && !dor_nien));

  a_r4_status_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb && !cs_cmd_n && cs_ctl_n && addr == 3'd7 &&
     dh_drv == strap_slave && !seq_done) |=> !irq_pend);

  a_r4_alt_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb && cs_cmd_n && !cs_ctl_n && addr == 3'd6 &&
     irq_pend && !dor_srst) |=> irq_pend);

  a_r6_srst_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dor_srst |-> busy);

  a_r6_init_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    init_wait |-> !irq_pend);

  a_r8_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_stb && !cs_cmd_n && cs_ctl_n && !seq_upd && !dor_srst) |=>
    ($stable(sc_q) && $stable(sn_q) && $stable(cl_q) && $stable(ch_q)));

  a_r11_strobe_src: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> $past(wr_stb && !cs_cmd_n && cs_ctl_n && addr == 3'd7));

endmodule

bind taskfile_regs taskfile_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .strap_slave(strap_slave),
  .cs_cmd_n(cs_cmd_n), .cs_ctl_n(cs_ctl_n), .addr(addr),
  .rd_stb(rd_stb), .wr_stb(wr_stb), .dd_oe(dd_oe), .intrq_oe(intrq_oe),
  .cmd_strobe(cmd_strobe), .seq_done(seq_done), .seq_upd(seq_upd),
  .busy(busy), .init_wait(init_wait), .irq_pend(irq_pend),
  .dor_srst(dor_srst), .dor_nien(dor_nien), .dh_drv(dh_drv),
  .sc_q(sc_q), .sn_q(sn_q), .cl_q(cl_q), .ch_q(ch_q)
);

// File: tb/tb_taskfile_regs.sv
module tb_taskfile_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, strap_slave = 1'b0;
  logic        cs_cmd_n = 1'b1, cs_ctl_n = 1'b1, rd_stb = 1'b0, wr_stb = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'h0, rdata, dport_wdata, dport_rdata = 16'hBEEF;
  logic [2:0]  dd_oe;
  logic        iocs16_n, intrq, intrq_oe, drive_rst, cmd_strobe, dport_rd, dport_wr;
  logic [7:0]  cmd_code, tf_precomp, tf_sc, tf_sn;
  logic [15:0] tf_cyl;
  logic [3:0]  tf_head;
  logic        tf_drv;
  logic [6:0]  drv_status = 7'h50;
  logic        wr_gate_n = 1'b1, init_done = 1'b0, seq_done = 1'b0;
  logic [7:0]  seq_err = 8'h00, seq_sc = 8'h00, seq_sn = 8'h00;
  logic        seq_busy_set = 1'b0, seq_upd = 1'b0;
  logic [15:0] seq_cyl = 16'h0;
  logic [3:0]  seq_head = 4'h0;

  int n_chk = 0, n_fail = 0;

  taskfile_regs dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  localparam logic [23:0] VEC [13] = '{
    {2'b01, 3'd1, 3'b011, 16'h0001},
    {2'b01, 3'd2, 3'b011, 16'h0012},
    {2'b01, 3'd3, 3'b011, 16'h0034},
    {2'b01, 3'd4, 3'b011, 16'h0056},
    {2'b01, 3'd5, 3'b011, 16'h0078},
    {2'b01, 3'd6, 3'b011, 16'h00A3},
    {2'b01, 3'd7, 3'b011, 16'h0050},
    {2'b10, 3'd6, 3'b011, 16'h0050},
    {2'b10, 3'd7, 3'b001, 16'h0072},
    {2'b01, 3'd0, 3'b111, 16'hBEEF},
    {2'b11, 3'd2, 3'b000, 16'h0000},
    {2'b00, 3'd2, 3'b000, 16'h0000},
    {2'b10, 3'd3, 3'b000, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic cn, input logic tn, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cs_cmd_n = cn; cs_ctl_n = tn; addr = a; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; cs_cmd_n = 1'b1; cs_ctl_n = 1'b1;
  endtask

  task automatic bus_rd(input logic cn, input logic tn, input logic [2:0] a,
                        output logic [15:0] d, output logic [2:0] oe);
    @(negedge clk);
    cs_cmd_n = cn; cs_ctl_n = tn; addr = a; rd_stb = 1'b1;
    #1;
    d = rdata; oe = dd_oe;
    @(negedge clk);
    rd_stb = 1'b0; cs_cmd_n = 1'b1; cs_ctl_n = 1'b1;
  endtask

  task automatic rd_chk(input string tag, input logic cn, input logic tn,
                        input logic [2:0] a, input logic [2:0] eoe, input logic [15:0] ed);
    logic [15:0] d, m;
    logic [2:0]  oe;
    bus_rd(cn, tn, a, d, oe);
    m = eoe[2] ? 16'hFFFF : eoe[1] ? 16'h00FF : eoe[0] ? 16'h007F : 16'h0000;
    chk(tag, {13'h0, oe, d & m}, {13'h0, eoe, ed & m});
  endtask

  task automatic pulse_done(input logic [7:0] e);
    @(negedge clk); seq_err = e; seq_done = 1'b1;
    @(negedge clk); seq_done = 1'b0;
  endtask

  task automatic pulse_init();
    @(negedge clk); init_done = 1'b1;
    @(negedge clk); init_done = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 drive_rst under hw reset", drive_rst, 1);
    rst_n = 1'b1;
    rd_chk("R6 busy after hw reset", 0, 1, 3'd7, 3'b011, 16'h00D0);
    pulse_init();
    // R7 defaults
    rd_chk("R7 error default", 0, 1, 3'd1, 3'b011, 16'h0001);
    rd_chk("R7 sector count default", 0, 1, 3'd2, 3'b011, 16'h0001);
    rd_chk("R7 sector number default", 0, 1, 3'd3, 3'b011, 16'h0001);
    rd_chk("R7 cyl low default", 0, 1, 3'd4, 3'b011, 16'h0000);
    rd_chk("R7 cyl high default", 0, 1, 3'd5, 3'b011, 16'h0000);
    rd_chk("R7 drive/head default", 0, 1, 3'd6, 3'b011, 16'h00A0);
    rd_chk("R6 ready after init", 0, 1, 3'd7, 3'b011, 16'h0050);
    rd_chk("R10 drive address default", 1, 0, 3'd7, 3'b001, 16'h007E);
    chk("R6 no irq after init", intrq_oe, 0);

    bus_wr(0, 1, 3'd2, 16'h0012);
    bus_wr(0, 1, 3'd3, 16'h0034);
    bus_wr(0, 1, 3'd4, 16'h0056);
    bus_wr(0, 1, 3'd5, 16'h0078);
    bus_wr(0, 1, 3'd6, 16'h0003);
    bus_wr(0, 1, 3'd1, 16'h0099);
    bus_wr(1, 1, 3'd2, 16'h00EE);
    bus_wr(0, 0, 3'd3, 16'h00EE);
    bus_wr(1, 0, 3'd2, 16'h00EE);
    chk("R2 precomp loaded", tf_precomp, 8'h99);
    chk("R3 invalid writes ignored", {tf_sc, tf_sn}, 16'h1234);

    for (int i = 0; i < 13; i++) begin
      logic [23:0] v;
      string tag;
      v = VEC[i];
      if (v[18:16] == 3'b000) tag = "R3 vector";
      else if (v[23:22] == 2'b10 && v[21:19] == 3'd7) tag = "R10 vector";
      else if (v[23:22] == 2'b10) tag = "R3 vector";
      else if (v[21:19] == 3'd6) tag = "R9 vector";
      else tag = "R1 vector";
      rd_chk(tag, v[23], v[22], v[21:19], v[18:16], v[15:0]);
    end

    // R11 R8 non-data command
    bus_wr(0, 1, 3'd7, 16'h0020);
    chk("R11 strobe", {cmd_strobe, cmd_code}, {1'b1, 8'h20});
    rd_chk("R11 busy set", 0, 1, 3'd7, 3'b011, 16'h00D0);
    rd_chk("R8 shadowed read", 0, 1, 3'd2, 3'b011, 16'h00D0);
    bus_wr(0, 1, 3'd2, 16'h0077);
    pulse_done(8'h04);
    rd_chk("R8 write ignored when busy", 0, 1, 3'd2, 3'b011, 16'h0012);
    rd_chk("R13 error loaded", 0, 1, 3'd1, 3'b011, 16'h0004);
    chk("R5 intrq raised", intrq_oe, 1);
    rd_chk("R4 alt status", 1, 0, 3'd6, 3'b011, 16'h0050);
    chk("R4 alt keeps irq", intrq_oe, 1);
    rd_chk("R4 status read", 0, 1, 3'd7, 3'b011, 16'h0050);
    chk("R4 status acks irq", intrq_oe, 0);

    bus_wr(0, 1, 3'd7, 16'h0030);
    chk("R11 write cmd strobe", {cmd_strobe, cmd_code}, {1'b1, 8'h30});
    rd_chk("R11 data-out cmd keeps busy clear", 0, 1, 3'd7, 3'b011, 16'h0050);

    bus_wr(1, 0, 3'd6, 16'h0002);
    pulse_done(8'h00);
    chk("R5 masked", intrq_oe, 0);
    bus_wr(1, 0, 3'd6, 16'h0000);
    chk("R5 unmasked", intrq_oe, 1);
    bus_wr(0, 1, 3'd6, 16'h0010);
    chk("R5 R12 deselected no irq", intrq_oe, 0);
    rd_chk("R12 deselected read quiet", 0, 1, 3'd7, 3'b000, 16'h0000);
    bus_wr(0, 1, 3'd2, 16'h0044);
    bus_wr(0, 1, 3'd6, 16'h0000);
    rd_chk("R12 deselected write taken", 0, 1, 3'd2, 3'b011, 16'h0044);
    rd_chk("R4 ack", 0, 1, 3'd7, 3'b011, 16'h0050);

    @(negedge clk);
    seq_sc = 8'h05; seq_sn = 8'h06; seq_cyl = 16'h0102; seq_head = 4'h9; seq_upd = 1'b1;
    @(negedge clk); seq_upd = 1'b0;
    rd_chk("R13 upd sc", 0, 1, 3'd2, 3'b011, 16'h0005);
    rd_chk("R13 upd sn", 0, 1, 3'd3, 3'b011, 16'h0006);
    rd_chk("R13 upd cyl lo", 0, 1, 3'd4, 3'b011, 16'h0002);
    rd_chk("R13 upd cyl hi", 0, 1, 3'd5, 3'b011, 16'h0001);
    rd_chk("R13 R9 upd head", 0, 1, 3'd6, 3'b011, 16'h00A9);

    bus_wr(1, 0, 3'd6, 16'h0004);
    chk("R6 srst drive_rst", drive_rst, 1);
    rd_chk("R6 srst busy", 0, 1, 3'd7, 3'b011, 16'h00D0);
    bus_wr(1, 0, 3'd6, 16'h0000);
    chk("R6 srst released", drive_rst, 0);
    rd_chk("R6 busy until init", 0, 1, 3'd7, 3'b011, 16'h00D0);
    pulse_init();
    rd_chk("R6 ready after srst", 0, 1, 3'd7, 3'b011, 16'h0050);
    rd_chk("R7 sc after srst", 0, 1, 3'd2, 3'b011, 16'h0001);
    rd_chk("R7 dh after srst", 0, 1, 3'd6, 3'b011, 16'h00A0);
    chk("R6 no irq after srst", intrq_oe, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule